// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request port and an external byte-wide asynchronous static RAM with a 15-bit address. It turns each accepted request into a single read or write access on the memory pins. It drives active-low chip select, write enable and output enable, the address, and the outgoing data together with an enable for the tri-state data buffer. The incoming data is returned to the requester.

Every memory timing minimum is a nanosecond parameter. The controller converts it to a whole number of system-clock cycles by rounding up, with a minimum of one cycle. Output enable stays high for every write, so the short write pulse is allowed. Bus turnaround is ordered so that the controller's data drivers and the memory's outputs are never on at the same time.

The request side works as a valid/ready stream with `busy` as the inverted ready. A request is taken on the clock edge where `req_valid` is high and `busy` is low. While `busy` is high, `req_valid` and the request fields are ignored, and the requester keeps its request pending. The read response has no back-pressure. `rd_valid` is high for exactly one cycle with `rd_data`, and the consumer must take it in that cycle.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, and `sram_dq_oe`, `busy` and `rd_valid` are 0.
- R2: A request is accepted only on an edge where `req_valid`=1 and `busy`=0. `busy` is 1 from the next cycle until the access and its deselect gap have finished. A request presented while `busy`=1 does not change the pin sequence.
- R3: A read (`req_we`=0) holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for C_ACC cycles. The data is sampled on the edge that ends the last of those cycles. `rd_valid`=1 for exactly the following cycle, with `rd_data` equal to the sampled byte.
- R4: A write (`req_we`=1) holds `sram_cs_n`=0 and `sram_we_n`=0 together for C_WLOW cycles. `sram_oe_n` stays 1 throughout, and `sram_we_n` is never 0 while `sram_cs_n` is 1.
- R5: `sram_dq_oe` is 1 from the second cycle of the write pulse through the single cycle after `sram_we_n` rises, and 0 at every other time. While it is 1, `sram_dq_out` equals the accepted `req_wdata`.
- R6: `sram_addr` equals the accepted `req_addr` during every cycle with `sram_cs_n`=0, and in the cycle after `sram_cs_n` rises.
- R7: After a read, `sram_cs_n` stays 1 for C_OFF cycles before the idle cycle. After a write, it stays 1 for one cycle before the idle cycle. Chip select is therefore never low in two accesses back to back.
- R8: Each cycle count is ceil(ns / CLK_NS), with a minimum of 1. C_ACC uses the larger of the address and select access times. C_WLOW = max(C_WP, C_DSU+1, C_WC-1).
- R9: `sram_dq_oe` is never 1 in a cycle where `sram_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| busy | output | 1 | Access in progress; requests ignored |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | DATA_W | Read byte, valid with rd_valid |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_oe | output | 1 | Enable for the data pad drivers |
| sram_dq_out | output | DATA_W | Data driven toward the memory |
| sram_dq_in | input | DATA_W | Data received from the memory pads |

## Verification
The bench uses a 4 ns clock with access times of 12/10 ns, an 8 ns write pulse, a 6 ns data setup, a 12 ns write cycle and a 6 ns output-off time. These values give a 3-cycle read and a 2-cycle post-read gap. The write pulse is 3 cycles, and it is set by the data-setup term (2+1 cycles) rather than by the 2-cycle pulse minimum, so the rule that takes the largest of the three terms is exercised. The memory model in the bench returns valid data only in the last access cycle, so sampling one edge early produces a wrong byte.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_GAP,
    ST_WR,
    ST_WR_END
  } seq_state_e;

  // Round a nanosecond minimum up to clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_port_timer.sv
module sram_port_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  // Loaded with N on entry to a phase; 'last' marks the Nth cycle of it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sram_port_seq.sv
module sram_port_seq
  import sram_port_pkg::*;
#(
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned C_ACC  = 3,
  parameter int unsigned C_WLOW = 3,
  parameter int unsigned C_OFF  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_we,
  input  logic             tmr_last,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture,
  output logic             busy,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  seq_state_e state_q, state_d;
  logic busy_q, cs_n_q, we_n_q, oe_n_q, dq_oe_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          tmr_load = 1'b1;
          if (start_we) begin
            state_d = ST_WR;
            tmr_val = CNT_W'(C_WLOW);
          end else begin
            state_d = ST_RD;
            tmr_val = CNT_W'(C_ACC);
          end
        end
      end
      ST_RD: begin
        if (tmr_last) begin
          state_d  = ST_RD_GAP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_OFF);
          capture  = 1'b1;
        end
      end
      ST_RD_GAP: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      ST_WR: begin
        if (tmr_last) state_d = ST_WR_END;
      end
      ST_WR_END: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Pin controls are registered from the next state so they leave flops cleanly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= (state_d != ST_IDLE);
      cs_n_q  <= !((state_d == ST_RD) || (state_d == ST_WR));
      we_n_q  <= !(state_d == ST_WR);
      oe_n_q  <= !(state_d == ST_RD);
      dq_oe_q <= ((state_d == ST_WR) && (state_q == ST_WR)) || (state_d == ST_WR_END);
    end
  end

  assign busy  = busy_q;
  assign cs_n  = cs_n_q;
  assign we_n  = we_n_q;
  assign oe_n  = oe_n_q;
  assign dq_oe = dq_oe_q;

endmodule

// File: rtl/sram_port_dpath.sv
module sram_port_dpath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  // Address and write data stay put from acceptance until the next request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= dq_in;
    end
  end

  assign mem_addr = addr_q;
  assign dq_out   = wdata_q;
  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CLK_NS   = 4,
  parameter int unsigned T_AA_NS  = 12,
  parameter int unsigned T_ACS_NS = 12,
  parameter int unsigned T_WP_NS  = 8,
  parameter int unsigned T_DSU_NS = 6,
  parameter int unsigned T_WC_NS  = 12,
  parameter int unsigned T_OFF_NS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_dq_oe,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned T_ACC_NS = (T_AA_NS > T_ACS_NS) ? T_AA_NS : T_ACS_NS;
  localparam int unsigned C_ACC    = ns_to_cyc(T_ACC_NS, CLK_NS);
  localparam int unsigned C_WP     = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int unsigned C_DSU    = ns_to_cyc(T_DSU_NS, CLK_NS);
  localparam int unsigned C_WC     = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned C_OFF    = ns_to_cyc(T_OFF_NS, CLK_NS);
  // Data drivers start one cycle late, so setup needs one extra pulse cycle;
  // the deselect cycle after the pulse counts toward the write cycle time.
  localparam int unsigned C_WLOW   = max3(C_WP, C_DSU + 1, (C_WC > 1) ? C_WC - 1 : 1);
  localparam int unsigned C_MAX    = max3(C_ACC, C_WLOW, C_OFF);
  localparam int unsigned CNT_W    = $clog2(C_MAX + 1);

  logic             accept;
  logic             tmr_load, tmr_last, capture;
  logic [CNT_W-1:0] tmr_val;

  assign accept = req_valid && !busy;

  sram_port_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_port_seq #(
    .CNT_W  (CNT_W),
    .C_ACC  (C_ACC),
    .C_WLOW (C_WLOW),
    .C_OFF  (C_OFF)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_we (req_we),
    .tmr_last (tmr_last),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .capture  (capture),
    .busy     (busy),
    .cs_n     (sram_cs_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe)
  );

  sram_port_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .capture   (capture),
    .dq_in     (sram_dq_in),
    .mem_addr  (sram_addr),
    .dq_out    (sram_dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk #(
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned MIN_WLOW = 1,
  parameter int unsigned MIN_ACC  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] addr
);

  logic [15:0] wlow_cnt, olow_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow_cnt <= '0;
      olow_cnt <= '0;
    end else begin
      wlow_cnt <= (!we_n && wlow_cnt != 16'hFFFF) ? wlow_cnt + 1'b1 : (!we_n ? wlow_cnt : '0);
      olow_cnt <= (!oe_n && olow_cnt != 16'hFFFF) ? olow_cnt + 1'b1 : (!oe_n ? olow_cnt : '0);
    end
  end

  AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !cs_n); // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> oe_n); // R4
  AST_WPULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (wlow_cnt >= 16'(MIN_WLOW))); // R4
  AST_ACCESS_MIN: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (olow_cnt >= 16'(MIN_ACC))); // R3
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R3
  AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n) $rose(dq_oe) |-> (!we_n && $past(!we_n))); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> oe_n); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && $past(!cs_n)) |-> $stable(addr)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> $stable(addr)); // R6
  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n); // R7

endmodule

bind sram_port_ctrl sram_port_chk #(
  .ADDR_W   (ADDR_W),
  .MIN_WLOW (C_WLOW),
  .MIN_ACC  (C_ACC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (sram_cs_n),
  .we_n     (sram_we_n),
  .oe_n     (sram_oe_n),
  .dq_oe    (sram_dq_oe),
  .rd_valid (rd_valid),
  .addr     (sram_addr)
);

// File: tb/tb_sram_port_ctrl.sv
`timescale 1ns/1ps
module tb_sram_port_ctrl;

  localparam int CLK_NS = 4;
  localparam int T_AA = 12, T_ACS = 10, T_WP = 8, T_DSU = 6, T_WC = 12, T_OFF = 6;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R8: counts derived here from the stated rounding rule
  localparam int E_ACC  = cyc(imax(T_AA, T_ACS));
  localparam int E_OFF  = cyc(T_OFF);
  localparam int E_WLOW = imax(imax(cyc(T_WP), cyc(T_DSU) + 1), imax(cyc(T_WC) - 1, 1));
  localparam logic [7:0] UNWRITTEN = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, rd_valid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0] rd_data, sram_dq_out;
  logic [7:0] sram_dq_in = 8'hEE;
  logic [14:0] sram_addr;

  always #2 clk = ~clk;

  sram_port_ctrl #(
    .CLK_NS(CLK_NS), .T_AA_NS(T_AA), .T_ACS_NS(T_ACS), .T_WP_NS(T_WP),
    .T_DSU_NS(T_DSU), .T_WC_NS(T_WC), .T_OFF_NS(T_OFF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .sram_addr(sram_addr), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in)
  );

  typedef struct {
    logic cs_n, we_n, oe_n, dq_oe, busy, rd_valid;
    logic [7:0] rdata, wdata;
    logic [14:0] addr;
    int kind;  // 0 idle, 1 read access, 2 write pulse, 3 deselect gap
  } frame_t;

  typedef struct {
    logic we;
    logic [14:0] addr;
    logic [7:0] data;
    int pre;
  } cmd_t;

  frame_t exp_q[$];
  cmd_t   cmd_q[$];
  logic [7:0] golden[int];
  logic [7:0] mem[int];

  int checks = 0, failures = 0;
  int idle_run = 0, rdcnt = 0;
  bit running = 1'b0, done = 1'b0, junk_tog = 1'b0;
  bit in_w = 1'b0, wl_v = 1'b0;
  logic [7:0] wl_d;
  logic [14:0] wl_a;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
    end
  endtask

  function automatic frame_t mk(input logic cs, input logic we, input logic oe, input logic dqo,
                                input logic bsy, input int kind, input logic [14:0] a);
    frame_t f;
    f.cs_n = cs; f.we_n = we; f.oe_n = oe; f.dq_oe = dqo; f.busy = bsy;
    f.rd_valid = 1'b0; f.rdata = '0; f.wdata = '0; f.addr = a; f.kind = kind;
    return f;
  endfunction

  function automatic logic [7:0] look(input logic [7:0] arr[int], input int a);
    return arr.exists(a) ? arr[a] : UNWRITTEN;
  endfunction

  task automatic issue(input cmd_t c);
    frame_t f;
    req_valid = 1'b1; req_we = c.we; req_addr = c.addr; req_wdata = c.data;
    if (c.we) begin
      for (int k = 0; k < E_WLOW; k++) begin
        f = mk(1'b0, 1'b0, 1'b1, (k >= 1), 1'b1, 2, c.addr);
        f.wdata = c.data;
        exp_q.push_back(f);
      end
      f = mk(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3, c.addr);
      f.wdata = c.data;
      exp_q.push_back(f);
      golden[int'(c.addr)] = c.data;
    end else begin
      for (int k = 0; k < E_ACC; k++) exp_q.push_back(mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1, c.addr));
      for (int k = 0; k < E_OFF; k++) begin
        f = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3, c.addr);
        if (k == 0) begin
          f.rd_valid = 1'b1;
          f.rdata = look(golden, int'(c.addr));
        end
        exp_q.push_back(f);
      end
    end
  endtask

  // Memory model: read data appears only in the last access cycle.
  always @(posedge clk) begin
    if (!sram_cs_n && !sram_oe_n) rdcnt <= rdcnt + 1;
    else rdcnt <= 0;
  end

  always @(negedge clk) begin
    frame_t f;
    bit idle_now;
    string sel;
    if (rst_n && running) begin
      if (exp_q.size() > 0) begin
        f = exp_q.pop_front();
        idle_now = 1'b0;
      end else begin
        f = mk(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, '0);
        idle_now = 1'b1;
      end
      sel = (f.kind == 1) ? "R3 R8" : (f.kind == 2) ? "R4 R8" : "R7";
      chk(sram_cs_n == f.cs_n, sel, "cs_n", sram_cs_n, f.cs_n);
      chk(sram_we_n == f.we_n, sel, "we_n", sram_we_n, f.we_n);
      chk(sram_oe_n == f.oe_n, sel, "oe_n", sram_oe_n, f.oe_n);
      chk(busy == f.busy, "R2", "busy", busy, f.busy);
      chk(sram_dq_oe == f.dq_oe, "R5", "dq_oe", sram_dq_oe, f.dq_oe);
      if (f.dq_oe) chk(sram_dq_out == f.wdata, "R5", "dq_out", sram_dq_out, f.wdata);
      chk(rd_valid == f.rd_valid, "R3", "rd_valid", rd_valid, f.rd_valid);
      if (f.rd_valid) chk(rd_data == f.rdata, "R3", "rd_data", rd_data, f.rdata);
      if (f.kind != 0) chk(sram_addr == f.addr, "R6", "addr", sram_addr, f.addr);
      chk(!(sram_dq_oe && !sram_oe_n), "R9", "dq_oe&oe", sram_dq_oe, 0);

      // memory write commit at the end of the select/write overlap
      if (!sram_cs_n && !sram_we_n) begin
        in_w = 1'b1;
        wl_a = sram_addr;
        if (sram_dq_oe) begin
          wl_d = sram_dq_out;
          wl_v = 1'b1;
        end
      end else if (in_w) begin
        if (wl_v) mem[int'(wl_a)] = wl_d;
        in_w = 1'b0;
        wl_v = 1'b0;
      end
      if (!sram_cs_n && !sram_oe_n && sram_we_n && rdcnt >= E_ACC - 1)
        sram_dq_in = look(mem, int'(sram_addr));
      else
        sram_dq_in = 8'hEE;

      // stimulus
      if (idle_now) idle_run++;
      else idle_run = 0;
      req_valid = 1'b0;
      if (idle_now && cmd_q.size() > 0 && idle_run > cmd_q[0].pre) begin
        issue(cmd_q.pop_front());
      end else if (!idle_now) begin
        // R2: junk requests while busy must leave the pin sequence untouched
        junk_tog = ~junk_tog;
        if (junk_tog) begin
          req_valid = 1'b1; req_we = ~req_we; req_addr = 15'h5A5A; req_wdata = 8'h99;
        end
      end
      if (idle_now && cmd_q.size() == 0 && idle_run > 3) done = 1'b1;
    end
  end

  task automatic add(input logic we, input logic [14:0] a, input logic [7:0] d, input int pre);
    cmd_t c;
    c.we = we; c.addr = a; c.data = d; c.pre = pre;
    cmd_q.push_back(c);
  endtask

  initial begin
    int wd;
    add(1'b1, 15'h0000, 8'h11, 0);
    add(1'b1, 15'h7FFF, 8'hEE, 2);
    add(1'b0, 15'h0000, 8'h00, 0);
    add(1'b0, 15'h7FFF, 8'h00, 0);
    add(1'b0, 15'h0155, 8'h00, 1);   // never written
    add(1'b1, 15'h1234, 8'h5A, 0);
    add(1'b0, 15'h1234, 8'h00, 0);   // write then read
    add(1'b1, 15'h1234, 8'hA7, 0);   // read then write turnaround
    add(1'b0, 15'h1234, 8'h00, 3);
    add(1'b1, 15'h2AAA, 8'h3C, 0);
    add(1'b1, 15'h0001, 8'h0F, 0);   // write after write
    add(1'b0, 15'h0001, 8'h00, 0);
    add(1'b0, 15'h2AAA, 8'h00, 0);   // read after read

    repeat (3) @(negedge clk);
    // R1: reset values, with a request pending during reset
    req_valid = 1'b1;
    @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1", "strobes", {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
    chk(!sram_dq_oe && !busy && !rd_valid, "R1", "dq_oe/busy/rd_valid",
        {sram_dq_oe, busy, rd_valid}, 3'b000);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_cs_n && !busy && !sram_dq_oe, "R1", "after release", {sram_cs_n, busy, sram_dq_oe}, 3'b100);
    running = 1'b1;

    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) chk(1'b0, "R2", "watchdog", wd, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule